// File: doc/BRIEF.md
# Sleep Interval Timer with Rollover Watchdog

This block is a free-running 15-bit up-counter on the slow (about 32.768 kHz) clock. It has no enable: it counts in active and in low-power states alike. A 2-bit rate selector picks one of four counter taps. Each time the bits at and below that tap wrap from all ones to zero, the block posts a single-cycle wake/interrupt pulse. The rates are 512 Hz, 64 Hz, 8 Hz and 1 Hz at the nominal clock.

The same rollover events drive a watchdog. The watchdog is not a separate counter: it counts selected-rate rollovers and raises a hardware reset request on the third rollover that arrives with no service write in between. Software serves it by writing to a single clear register. Any write there restarts the watchdog count. A write carrying the key value 0x38 also zeroes the timer itself. Once armed, the watchdog stays armed until the block's own power-on reset.

Top module: `slptmr_wdog`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `tmr_value` is 0, `tick_irq` is 0 and `wd_reset` is 0. The watchdog is disarmed.
- R2: With no key write, `tmr_value` increases by one on every clock and wraps from 32767 to 0.
- R3: The tap is bit 5 + 3*`rate_sel`. This gives one pulse every 64 clocks for `rate_sel`=00, every 512 clocks for 01, every 4096 clocks for 10, and every 32768 clocks for 11 (full wrap).
- R4: `tick_irq` is high for exactly one clock. It is high in the cycle in which `tmr_value` bits [tap:0] have just become zero after all ones.
- R5: A write (`clr_we`=1) with `clr_wdata`=0x38 sets `tmr_value` to 0 at that edge. No rollover pulse is posted at that edge.
- R6: A write with any other data value leaves the counter sequence unchanged.
- R7: Any write restarts the watchdog rollover count from zero. A rollover at the same edge as a write is not counted.
- R8: Before `wd_arm` has been pulsed, `wd_reset` never rises. Once armed, the watchdog stays armed: writes do not disarm it, a second `wd_arm` changes nothing, and only `rst` disarms it.
- R9: When armed, the third counted rollover raises `wd_reset` at the same edge as that rollover's `tick_irq`. `wd_reset` stays high for exactly 4 clocks. The rollover count then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rate_sel | input | 2 | Interrupt interval select (00 fastest, 11 slowest) |
| clr_we | input | 1 | Write strobe for the clear register |
| clr_wdata | input | 8 | Data of the clear register write; 0x38 also zeroes the timer |
| wd_arm | input | 1 | Pulse to arm the watchdog (sticky) |
| tmr_value | output | 15 | Current counter value |
| tick_irq | output | 1 | One-clock interval interrupt pulse |
| wd_reset | output | 1 | Watchdog hardware reset request, 4 clocks long |

## Verification
Several properties are checked in every cycle:
- the counter's increment by one;
- the zeroing after a key write;
- the single-cycle width of the interrupt and its alignment to zeroed low counter bits;
- the bound on the watchdog count, and its restart after every write;
- the arm flag never dropping outside reset;
- no reset request while disarmed, and every new reset request coinciding with a rollover.

Other behaviour is shown only by the bench's scenarios:
- the exact interval for each rate code;
- suppression of a rollover by a simultaneous key write;
- that non-key data leaves the counter alone;
- the escalation to reset after exactly three unserviced intervals, and the 4-cycle reset width.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int N_RATES = 4;
  typedef logic [1:0] rate_t;

  // Counter bit whose wrap defines the interval for a given rate code
  function automatic int tap_bit(input int lo, input int step, input int code);
    return lo + step * code;
  endfunction
endpackage

// File: rtl/stw_counter.sv
module stw_counter #(
  parameter int CNT_W = 15,
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] CLR_KEY = 8'h38
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_we,
  input  logic [KEY_W-1:0] clr_wdata,
  output logic [CNT_W-1:0] value,
  output logic             key_hit
);
  assign key_hit = clr_we && (clr_wdata == CLR_KEY);

  always_ff @(posedge clk) begin
    if (rst)          value <= '0;
    else if (key_hit) value <= '0;
    else              value <= value + 1'b1;
  end

  // R2
  inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(key_hit)) |-> value == $past(value) + 1'b1);
  // R5
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    key_hit |=> value == '0);
endmodule

// File: rtl/stw_tick.sv
module stw_tick #(
  parameter int CNT_W    = 15,
  parameter int TAP_LO   = 5,
  parameter int TAP_STEP = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  stw_pkg::rate_t    rate_sel,
  input  logic [CNT_W-1:0]  value,
  input  logic              key_hit,
  output logic              roll,
  output logic              irq
);
  import stw_pkg::*;
  localparam int TOP_TAP = tap_bit(TAP_LO, TAP_STEP, N_RATES - 1);

  logic [N_RATES-1:0] full;

  generate
    for (genvar g = 0; g < N_RATES; g++) begin : g_tap
      localparam int TB = tap_bit(TAP_LO, TAP_STEP, g);
      assign full[g] = &value[TB:0];
    end
  endgenerate

  // A wrap happens at the next edge unless a key write zeroes the counter first
  assign roll = full[rate_sel] && !key_hit;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= roll;
  end

  initial begin
    tap_fit_chk: assert (TOP_TAP <= CNT_W - 1);
  end

  // R4
  irq_gap_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R4
  irq_align_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> value[TAP_LO:0] == '0);
endmodule

// File: rtl/stw_wdog.sv
module stw_wdog #(
  parameter int WD_LIMIT = 3,
  parameter int RST_LEN  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic clr_we,
  input  logic roll,
  output logic wd_rst
);
  localparam int CW = (WD_LIMIT > 1) ? $clog2(WD_LIMIT) : 1;
  localparam int HW = $clog2(RST_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(WD_LIMIT - 1);

  logic          en;
  logic [CW-1:0] wd_cnt;
  logic [HW-1:0] hold, hold_nxt;
  logic          fire;

  assign fire = en && roll && !clr_we && (wd_cnt == LAST);

  always_comb begin
    if (fire)           hold_nxt = HW'(RST_LEN);
    else if (hold != 0) hold_nxt = hold - 1'b1;
    else                hold_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      wd_cnt <= '0;
      hold   <= '0;
      wd_rst <= 1'b0;
    end else begin
      en     <= en | arm;
      hold   <= hold_nxt;
      wd_rst <= (hold_nxt != 0);
      if (clr_we)              wd_cnt <= '0;
      else if (en && roll)     wd_cnt <= fire ? '0 : wd_cnt + 1'b1;
    end
  end

  // R8
  arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> en);
  // R8
  no_rst_disarmed_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> !wd_rst);
  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    wd_cnt <= LAST);
  // R9
  rst_on_roll_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_rst) |-> $past(roll));
  // R7
  write_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> wd_cnt == '0);
endmodule

// File: rtl/slptmr_wdog.sv
module slptmr_wdog #(
  parameter int CNT_W    = 15,
  parameter int TAP_LO   = 5,
  parameter int TAP_STEP = 3,
  parameter int WD_LIMIT = 3,
  parameter int RST_LEN  = 4,
  parameter int KEY_W    = 8,
  parameter logic [KEY_W-1:0] CLR_KEY = 8'h38
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       rate_sel,
  input  logic             clr_we,
  input  logic [KEY_W-1:0] clr_wdata,
  input  logic             wd_arm,
  output logic [CNT_W-1:0] tmr_value,
  output logic             tick_irq,
  output logic             wd_reset
);
  logic key_hit;
  logic roll;

  stw_counter #(.CNT_W(CNT_W), .KEY_W(KEY_W), .CLR_KEY(CLR_KEY)) u_cnt (
    .clk(clk), .rst(rst), .clr_we(clr_we), .clr_wdata(clr_wdata),
    .value(tmr_value), .key_hit(key_hit)
  );

  stw_tick #(.CNT_W(CNT_W), .TAP_LO(TAP_LO), .TAP_STEP(TAP_STEP)) u_tick (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .value(tmr_value),
    .key_hit(key_hit), .roll(roll), .irq(tick_irq)
  );

  stw_wdog #(.WD_LIMIT(WD_LIMIT), .RST_LEN(RST_LEN)) u_wdog (
    .clk(clk), .rst(rst), .arm(wd_arm), .clr_we(clr_we),
    .roll(roll), .wd_rst(wd_reset)
  );
endmodule

// File: tb/tb_slptmr_wdog.sv
module tb_slptmr_wdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  rate_sel = 2'b00;
  logic        clr_we = 1'b0;
  logic [7:0]  clr_wdata = 8'h00;
  logic        wd_arm = 1'b0;
  logic [14:0] tmr_value;
  logic        tick_irq;
  logic        wd_reset;

  int total = 0, bad = 0;
  int m_cnt = 0, m_wdc = 0, m_hc = 0;
  bit m_irq = 0, m_rst = 0, m_wden = 0;
  int irq_seen = 0, rst_seen = 0, run_len = 0, last_len = 0;
  bit done = 0;

  slptmr_wdog dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .clr_we(clr_we),
    .clr_wdata(clr_wdata), .wd_arm(wd_arm), .tmr_value(tmr_value),
    .tick_irq(tick_irq), .wd_reset(wd_reset)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model step from the requirements, then one clock and compare
  task automatic cyc();
    int ta, mask;
    bit key, ev;
    if (rst) begin
      m_cnt = 0; m_irq = 0; m_rst = 0; m_wden = 0; m_wdc = 0; m_hc = 0;
    end else begin
      ta   = 5 + 3 * int'(rate_sel);
      mask = (1 << (ta + 1)) - 1;
      key  = clr_we && (clr_wdata == 8'h38);
      ev   = ((m_cnt & mask) == mask) && !key;
      m_cnt = key ? 0 : ((m_cnt + 1) & 32'h7fff);
      m_irq = ev;
      if (m_hc > 0) m_hc--;
      if (clr_we) m_wdc = 0;
      else if (ev && m_wden) begin
        if (m_wdc == 2) begin m_wdc = 0; m_hc = 4; end
        else m_wdc++;
      end
      m_rst = (m_hc != 0);
      if (wd_arm) m_wden = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(int'(tmr_value) == m_cnt, "R2 tmr_value", int'(tmr_value), m_cnt);
    chk(tick_irq == m_irq, "R4 tick_irq", int'(tick_irq), int'(m_irq));
    chk(wd_reset == m_rst, "R9 wd_reset", int'(wd_reset), int'(m_rst));
    if (tick_irq) irq_seen++;
    if (wd_reset && run_len == 0) rst_seen++;
    if (wd_reset) run_len++;
    else if (run_len != 0) begin last_len = run_len; run_len = 0; end
    clr_we = 1'b0;
    wd_arm = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input logic [7:0] d);
    clr_we = 1'b1;
    clr_wdata = d;
    cyc();
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog timeout");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int prev, snap;
    void'($urandom(32'd4242));
    // R1 reset state
    run(3);
    chk(tmr_value == 0 && !tick_irq && !wd_reset, "R1 reset outputs", int'(tmr_value), 0);
    rst = 1'b0;
    cyc();
    chk(tmr_value == 1, "R1 first count after reset", int'(tmr_value), 1);

    // R3 rate 00: 64-cycle interval
    wr(8'h38);
    irq_seen = 0; run(63);
    chk(irq_seen == 0, "R3 rate00 no early pulse", irq_seen, 0);
    run(1);
    chk(irq_seen == 1 && tick_irq, "R3 rate00 pulse at 64", irq_seen, 1);
    cyc();
    chk(!tick_irq, "R4 pulse one clock", int'(tick_irq), 0);

    // R5 key write zeroes and R6 other data ignored
    run(17);
    wr(8'h38);
    chk(tmr_value == 0, "R5 key clears timer", int'(tmr_value), 0);
    run(9);
    prev = int'(tmr_value);
    wr(8'h37);
    chk(int'(tmr_value) == prev + 1, "R6 non-key ignored", int'(tmr_value), prev + 1);
    // R5 key write on a would-be rollover edge suppresses the pulse
    while (m_cnt % 64 != 63) cyc();
    irq_seen = 0;
    wr(8'h38);
    chk(irq_seen == 0 && tmr_value == 0, "R5 rollover suppressed", irq_seen, 0);

    // R3 rates 01 and 10
    rate_sel = 2'b01; wr(8'h38); irq_seen = 0; run(511);
    chk(irq_seen == 0, "R3 rate01 no early pulse", irq_seen, 0);
    run(1);
    chk(irq_seen == 1, "R3 rate01 pulse at 512", irq_seen, 1);
    rate_sel = 2'b10; wr(8'h38); irq_seen = 0; run(4096);
    chk(irq_seen == 1 && tick_irq, "R3 rate10 pulse at 4096", irq_seen, 1);
    // R3 rate 11 and R2 full wrap
    rate_sel = 2'b11; wr(8'h38); irq_seen = 0; run(32767);
    chk(irq_seen == 0 && tmr_value == 15'h7fff, "R2 reaches max", int'(tmr_value), 32767);
    run(1);
    chk(irq_seen == 1 && tmr_value == 0, "R3 rate11 full wrap pulse", irq_seen, 1);

    // R8 disarmed: no reset over many rollovers
    rate_sel = 2'b00; rst_seen = 0; run(400);
    chk(rst_seen == 0, "R8 no reset while disarmed", rst_seen, 0);

    // R7 serviced watchdog never fires
    wd_arm = 1'b1; cyc();
    for (int k = 0; k < 8; k++) begin run(100); wr(8'h11); end
    chk(rst_seen == 0, "R7 serviced no reset", rst_seen, 0);
    // R7 write on a rollover edge: that rollover not counted
    while (m_cnt % 64 != 63) cyc();
    wr(8'h55);
    run(64 * 2 + 2);
    chk(rst_seen == 0, "R7 simultaneous write not counted", rst_seen, 0);
    // R9 third unserviced rollover fires, held 4
    run(64);
    chk(rst_seen == 1, "R9 reset after three intervals", rst_seen, 1);
    run(8);
    chk(last_len == 4, "R9 reset width", last_len, 4);
    // R8 second arm harmless, writes do not disarm
    wd_arm = 1'b1; cyc(); wr(8'h38);
    snap = rst_seen; run(64 * 3 + 4);
    chk(rst_seen == snap + 1, "R8 still armed after write", rst_seen, snap + 1);

    // Random mix
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 149) == 0) begin
        clr_we = 1'b1;
        clr_wdata = ($urandom_range(0, 1) == 1) ? 8'h38 : 8'($urandom_range(0, 255));
      end
      if ($urandom_range(0, 999) == 0) wd_arm = 1'b1;
      if ($urandom_range(0, 2999) == 0) rate_sel = 2'($urandom_range(0, 1));
      cyc();
    end

    // R1/R8 reset disarms
    rst = 1'b1; run(2); rst = 1'b0; rate_sel = 2'b00;
    snap = rst_seen; run(64 * 4);
    chk(rst_seen == snap, "R8 reset disarms watchdog", rst_seen, snap);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule